// File: doc/BRIEF.md
# Serial EEPROM Word Write Sequencer

This block is a hardware master for a three-wire serial EEPROM that stores 16-bit words. A client presents a 6-bit word address and a 16-bit value with a one-cycle request. The block then runs the whole programming chain on its own. It sends an enable-writes command, erases the addressed word, and releases chip select for a timed program pulse. Next it sends the write command with its address and both data bytes, releases chip select for a second timed pulse, and finally sends a disable-writes command. A one-cycle done pulse ends the job.

The program pulse inside the EEPROM lasts exactly as long as chip select stays low after an erase or write command. The block therefore measures both pauses with an internal counter built from a cycles-per-millisecond parameter and a millisecond count. The millisecond count is confined to the 16 to 25 ms band at elaboration. Between the enable command and the erase command, chip select drops only for a short, separately parameterised gap.

Out of reset, chip select is low and the block shifts one all-zero byte onto the data line, which ends any programming cycle that a reset cut short. Only after that does it accept requests. The serial clock is the system clock divided by a parameter, 128 by default. Data changes while the serial clock is low, so the EEPROM can sample it on the rising edge.

Top module: `mw_word_writer`

## Requirements
- R1: While reset is applied and right after it, `cs` and `sk` are low, `done` is low and `busy` is high. After reset, exactly 8 serial clock pulses are sent with `cs` low and `dout` low on every one, and only then does `busy` fall.
- R2: Each serial clock pulse is high for CLK_DIV/2 system cycles. Within one byte, consecutive rising edges of `sk` are CLK_DIV cycles apart. `sk` stays low whenever no byte is being shifted.
- R3: Bits go out most significant first. `dout` never changes while `sk` is high.
- R4: A `req` seen while `busy` is low captures `addr` and `wdata`, and `busy` is high from the next cycle until the job ends.
- R5: A job produces exactly four chip-select windows, each carrying a whole number of bytes, in this order. The enable frame is 16 bits, 0x0130. The erase frame is 16 bits: 0x01, then bits 11, then the address MSB first. The write frame is 32 bits: 0x01, then bits 01, then the address, then the 16 data bits MSB first. The disable frame is 16 bits, 0x0100.
- R6: Between the enable frame and the erase frame, `cs` is low for exactly GAP_CYC system cycles.
- R7: After the erase frame and after the write frame, `cs` is low for exactly PULSE_MS × CYC_PER_MS system cycles. PULSE_MS outside 16..25 is rejected at elaboration.
- R8: `done` is high for exactly one cycle at the end of a job. In that cycle `cs` is low and `busy` is already low.
- R9: A `req` that arrives while `busy` is high has no effect. The frames of the running job and its address and data are unchanged.
- R10: Apart from the reset flush byte, no serial clock pulse ever occurs while `cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start one word write (taken only when not busy) |
| addr | input | 6 | Word address to program |
| wdata | input | 16 | Word value to program |
| busy | output | 1 | Flush or job in progress |
| done | output | 1 | One-cycle pulse when a job has finished |
| cs | output | 1 | EEPROM chip select, active high |
| sk | output | 1 | Serial clock to the EEPROM |
| dout | output | 1 | Serial data to the EEPROM |

## Verification
The hardest conditions to reach from the ports are the exact lengths of the chip-select-low windows, and a request that lands in the middle of a running job. The bench shortens the timed pauses through the millisecond parameter and stamps every edge of `cs` against a free-running cycle count, so each window is checked to the cycle. It sweeps all 64 addresses with arithmetically derived data and a few extreme patterns. On one address in eight, it fires a second request with inverted address and data part-way through the erase command and then confirms that the captured frames still carry the first request.

// File: rtl/mw_pkg.sv
package mw_pkg;
   // kind of work done in one sequencer step
   typedef enum logic [1:0] {
      K_SEND  = 2'd0,
      K_GAP   = 2'd1,
      K_PULSE = 2'd2
   } step_kind_t;

   typedef enum logic [1:0] {
      S_FLUSH = 2'd0,
      S_IDLE  = 2'd1,
      S_RUN   = 2'd2
   } seq_state_t;

   // leading zeros followed by the start bit
   localparam logic [7:0] HEAD_BYTE  = 8'h01;
   localparam logic [7:0] WREN_TAIL  = 8'h30;
   localparam logic [7:0] WRDIS_TAIL = 8'h00;
   localparam logic [7:0] FLUSH_BYTE = 8'h00;
   localparam logic [1:0] OP_ERASE   = 2'b11;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam int         LAST_STEP  = 12;
   localparam int         STEP_W     = 4;
endpackage

// File: rtl/mw_shifter.sv
module mw_shifter #(
   parameter int CLK_DIV = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] byte_in,
   output logic       busy,
   output logic       done,
   output logic       sk,
   output logic       dout
);
   localparam int CNT_W = $clog2(CLK_DIV);
   localparam int HALF  = CLK_DIV / 2;
   localparam bit POW2  = (CLK_DIV & (CLK_DIV - 1)) == 0;

   logic [CNT_W-1:0] cnt;
   logic [2:0]       bitn;
   logic [7:0]       shreg;
   logic             active;
   logic             done_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         bitn   <= '0;
         shreg  <= '0;
         active <= 1'b0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (start && !active) begin
            shreg  <= byte_in;
            active <= 1'b1;
            cnt    <= '0;
            bitn   <= '0;
         end else if (active) begin
            if (cnt == CNT_W'(CLK_DIV - 1)) begin
               cnt   <= '0;
               shreg <= {shreg[6:0], 1'b0};
               bitn  <= bitn + 3'd1;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  done_r <= 1'b1;
               end
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   // serial clock: low half first, high half second
   generate
      if (POW2) begin : g_sk_msb
         assign sk = active & cnt[CNT_W-1];
      end else begin : g_sk_cmp
         assign sk = active & (cnt >= CNT_W'(HALF));
      end
   endgenerate

   assign dout = active & shreg[7];
   assign busy = active;
   assign done = done_r;

   // R3
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sk && $past(sk)) |-> $stable(dout));

   // R2
   byte_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> done);
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             exp_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         run   <= 1'b0;
         exp_r <= 1'b0;
      end else begin
         exp_r <= 1'b0;
         if (start) begin
            cnt <= len;
            run <= 1'b1;
         end else if (run) begin
            if (cnt <= CNT_W'(1)) begin
               run   <= 1'b0;
               exp_r <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

   assign busy    = run;
   assign expired = exp_r;

   // R7
   tmr_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> expired);
endmodule

// File: rtl/mw_seq.sv
module mw_seq
   import mw_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int TMR_W     = 8,
   parameter int GAP_CYC   = 100,
   parameter int PULSE_CYC = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sh_busy,
   input  logic              sh_done,
   input  logic              tmr_done,
   output logic              sh_start,
   output logic [7:0]        sh_byte,
   output logic              tmr_start,
   output logic [TMR_W-1:0]  tmr_len,
   output logic              cs,
   output logic              busy,
   output logic              done
);
   // timer load leaves room for the start and step-advance cycles
   localparam logic [TMR_W-1:0] GAP_LOAD   = TMR_W'(GAP_CYC - 2);
   localparam logic [TMR_W-1:0] PULSE_LOAD = TMR_W'(PULSE_CYC - 2);

   seq_state_t        state;
   logic [STEP_W-1:0] step;
   logic              launched;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              done_r;
   step_kind_t        kind;
   logic [7:0]        step_byte;
   logic              step_end;

   always_comb begin
      kind      = K_SEND;
      step_byte = FLUSH_BYTE;
      case (step)
         4'd0:  step_byte = HEAD_BYTE;
         4'd1:  step_byte = WREN_TAIL;
         4'd2:  kind      = K_GAP;
         4'd3:  step_byte = HEAD_BYTE;
         4'd4:  step_byte = {OP_ERASE, addr_q};
         4'd5:  kind      = K_PULSE;
         4'd6:  step_byte = HEAD_BYTE;
         4'd7:  step_byte = {OP_WRITE, addr_q};
         4'd8:  step_byte = data_q[DATA_W-1:8];
         4'd9:  step_byte = data_q[7:0];
         4'd10: kind      = K_PULSE;
         4'd11: step_byte = HEAD_BYTE;
         4'd12: step_byte = WRDIS_TAIL;
         default: step_byte = FLUSH_BYTE;
      endcase
   end

   assign sh_byte   = (state == S_FLUSH) ? FLUSH_BYTE : step_byte;
   assign sh_start  = !launched && !sh_busy &&
                      (state == S_FLUSH || (state == S_RUN && kind == K_SEND));
   assign tmr_start = !launched && state == S_RUN && kind != K_SEND;
   assign tmr_len   = (kind == K_GAP) ? GAP_LOAD : PULSE_LOAD;
   assign step_end  = (kind == K_SEND) ? sh_done : tmr_done;
   assign cs        = (state == S_RUN) && (kind == K_SEND);
   assign busy      = (state != S_IDLE);
   assign done      = done_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_FLUSH;
         step     <= '0;
         launched <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
         done_r   <= 1'b0;
      end else begin
         done_r <= 1'b0;
         case (state)
            S_FLUSH: begin
               if (sh_start) launched <= 1'b1;
               if (sh_done) begin
                  launched <= 1'b0;
                  state    <= S_IDLE;
               end
            end
            S_IDLE: begin
               if (req) begin
                  addr_q   <= addr;
                  data_q   <= wdata;
                  step     <= '0;
                  launched <= 1'b0;
                  state    <= S_RUN;
               end
            end
            S_RUN: begin
               if (sh_start || tmr_start) launched <= 1'b1;
               if (step_end) begin
                  launched <= 1'b0;
                  if (step == STEP_W'(LAST_STEP)) begin
                     step   <= '0;
                     state  <= S_IDLE;
                     done_r <= 1'b1;
                  end else begin
                     step <= step + STEP_W'(1);
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R9
   req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RUN && req) |=> ($stable(addr_q) && $stable(data_q)));

   // R1
   flush_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FLUSH && sh_busy) |-> !cs);
endmodule

// File: rtl/mw_word_writer.sv
module mw_word_writer #(
   parameter int CLK_DIV    = 128,
   parameter int CYC_PER_MS = 100000,
   parameter int PULSE_MS   = 20,
   parameter int GAP_CYC    = 100,
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic              cs,
   output logic              sk,
   output logic              dout
);
   localparam int PULSE_CYC = PULSE_MS * CYC_PER_MS;
   localparam int TMR_W     = $clog2(PULSE_CYC + 1);

   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 4");
      end
      if (PULSE_MS < 16 || PULSE_MS > 25) begin : g_bad_pulse
         $error("PULSE_MS must lie in 16..25");
      end
      if (GAP_CYC < 3 || GAP_CYC > PULSE_CYC) begin : g_bad_gap
         $error("GAP_CYC must be at least 3 and below the pulse length");
      end
      if (ADDR_W != 6 || DATA_W != 16) begin : g_bad_frame
         $error("frame layout needs a 6-bit address and 16-bit data");
      end
   endgenerate

   logic             sh_start, sh_busy, sh_done;
   logic [7:0]       sh_byte;
   logic             tmr_start, tmr_busy, tmr_done;
   logic [TMR_W-1:0] tmr_len;

   mw_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W),
      .GAP_CYC(GAP_CYC), .PULSE_CYC(PULSE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
      .sh_busy(sh_busy), .sh_done(sh_done), .tmr_done(tmr_done),
      .sh_start(sh_start), .sh_byte(sh_byte),
      .tmr_start(tmr_start), .tmr_len(tmr_len),
      .cs(cs), .busy(busy), .done(done)
   );

   mw_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .byte_in(sh_byte),
      .busy(sh_busy), .done(sh_done), .sk(sk), .dout(dout)
   );

   mw_timer #(.CNT_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
      .busy(tmr_busy), .expired(tmr_done)
   );

   // R7
   cs_low_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_busy |-> !cs);

   // R5
   cs_steady_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_busy && $past(sh_busy)) |-> $stable(cs));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cs && !busy));
endmodule

// File: tb/mw_word_writer_test.sv
module mw_word_writer_test;
   localparam int CLK_DIV    = 8;
   localparam int CYC_PER_MS = 4;
   localparam int PULSE_MS   = 20;
   localparam int GAP_CYC    = 5;
   localparam int PULSE_CYC  = PULSE_MS * CYC_PER_MS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [5:0]  addr_i = '0;
   logic [15:0] data_i = '0;
   logic        busy, done, cs, sk, dout;

   always #5 clk = ~clk;

   mw_word_writer #(
      .CLK_DIV(CLK_DIV), .CYC_PER_MS(CYC_PER_MS), .PULSE_MS(PULSE_MS),
      .GAP_CYC(GAP_CYC), .ADDR_W(6), .DATA_W(16)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr_i), .wdata(data_i),
      .busy(busy), .done(done), .cs(cs), .sk(sk), .dout(dout)
   );

   int checks = 0;
   int fails  = 0;

   // monitor state
   int          cyc = 0;
   int          nfr = 0;
   int          nbits = 0;
   logic [63:0] cur = '0;
   logic [63:0] frv [512];
   int          frn [512];
   int          lowlen [512];
   int          fall_cyc = 0;
   int          last_rise = 0;
   int          hi_run = 0;
   int          bad_period = 0;
   int          bad_hold = 0;
   int          low_bits = 0;
   int          low_ones = 0;
   int          done_cnt = 0;
   int          done_bad = 0;
   logic        sk_q = 1'b0, cs_q = 1'b0, dout_q = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sk) hi_run++;
         if (!sk && sk_q) begin
            if (hi_run != CLK_DIV / 2) bad_period++;
            hi_run = 0;
         end
         if (sk && !sk_q) begin
            if (cs) begin
               if ((nbits % 8) != 0 && (cyc - last_rise) != CLK_DIV) bad_period++;
               last_rise = cyc;
               cur = {cur[62:0], dout};
               nbits++;
            end else begin
               low_bits++;
               if (dout) low_ones++;
            end
         end
         if (sk && sk_q && dout != dout_q) bad_hold++;
         if (cs && !cs_q) begin
            if (nfr > 0 && nfr <= 512) lowlen[nfr-1] = cyc - fall_cyc;
            cur = '0;
            nbits = 0;
         end
         if (!cs && cs_q) begin
            if (nfr < 512) begin
               frv[nfr] = cur;
               frn[nfr] = nbits;
            end
            nfr++;
            fall_cyc = cyc;
         end
         if (done) begin
            done_cnt++;
            if (cs || busy) done_bad++;
         end
      end
      sk_q = sk;
      cs_q = cs;
      dout_q = dout;
   end

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy; i++) @(posedge clk);
   endtask

   task automatic run_one(input logic [5:0] a, input logic [15:0] d, input bit poke);
      int base;
      int d0;
      string rq;
      logic [63:0] e_ers, e_wr;
      wait_idle();
      @(posedge clk);
      base = nfr;
      d0   = done_cnt;
      @(negedge clk);
      addr_i = a; data_i = d; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      // R4
      chk(busy == 1'b1, "R4 busy after request", 64'(busy), 64'd1);
      if (poke) begin
         repeat (150) @(negedge clk);
         addr_i = ~a; data_i = ~d; req = 1'b1;
         @(negedge clk);
         req = 1'b0;
      end
      for (int i = 0; i < 20000 && done_cnt == d0; i++) @(posedge clk);
      repeat (3) @(posedge clk);
      rq = poke ? "R9" : "R5";
      e_ers = 64'({8'h01, 2'b11, a});
      e_wr  = 64'({8'h01, 2'b01, a, d});
      chk(nfr - base == 4, {rq, " frame count"}, 64'(nfr - base), 64'd4);
      chk(frn[base] == 16 && frv[base] == 64'h0130, {rq, " enable frame"},
          frv[base], 64'h0130);
      chk(frn[base+1] == 16 && frv[base+1] == e_ers, {rq, " erase frame"},
          frv[base+1], e_ers);
      chk(frn[base+2] == 32 && frv[base+2] == e_wr, {rq, " write frame"},
          frv[base+2], e_wr);
      chk(frn[base+3] == 16 && frv[base+3] == 64'h0100, {rq, " disable frame"},
          frv[base+3], 64'h0100);
      // R6
      chk(lowlen[base] == GAP_CYC, "R6 gap length", 64'(lowlen[base]), 64'(GAP_CYC));
      // R7
      chk(lowlen[base+1] == PULSE_CYC, "R7 erase pulse", 64'(lowlen[base+1]),
          64'(PULSE_CYC));
      chk(lowlen[base+2] == PULSE_CYC, "R7 write pulse", 64'(lowlen[base+2]),
          64'(PULSE_CYC));
      // R8
      chk(done_cnt - d0 == 1, "R8 done width", 64'(done_cnt - d0), 64'd1);
      chk(done_bad == 0, "R8 done with cs or busy", 64'(done_bad), 64'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs == 1'b0 && sk == 1'b0, "R1 cs/sk in reset", 64'({cs, sk}), 64'd0);
      chk(done == 1'b0 && busy == 1'b1, "R1 done/busy in reset",
          64'({done, busy}), 64'h1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs == 1'b0 && busy == 1'b1, "R1 after reset", 64'({cs, busy}), 64'h1);
      wait_idle();
      @(posedge clk);
      chk(low_bits == 8, "R1 flush pulse count", 64'(low_bits), 64'd8);
      chk(low_ones == 0, "R1 flush byte zero", 64'(low_ones), 64'd0);
      chk(nfr == 0, "R1 no cs during flush", 64'(nfr), 64'd0);
      chk(bad_period == 0, "R2 flush clock shape", 64'(bad_period), 64'd0);

      for (int a = 0; a < 64; a++) begin
         logic [15:0] d;
         d = 16'(a * 16'h0403) ^ 16'hA5C3;
         run_one(6'(a), d, (a % 8) == 3);
      end
      run_one(6'd0,  16'h0000, 1'b0);
      run_one(6'd63, 16'hFFFF, 1'b0);
      run_one(6'd42, 16'h8001, 1'b1);

      // R2
      chk(bad_period == 0, "R2 serial clock period", 64'(bad_period), 64'd0);
      // R3
      chk(bad_hold == 0, "R3 data stable while sk high", 64'(bad_hold), 64'd0);
      // R10
      chk(low_bits == 8, "R10 no pulses with cs low", 64'(low_bits), 64'd8);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule